// File: doc/BRIEF.md
# Galloping-Ones Memory Self-Test Controller

This block tests a word-organized single-port SRAM by treating every bit of every word as its own cell. After a start request it zeroes the entire array. It then places a lone 1 in one cell at a time. For each placement it reads the whole array back and compares it before it clears that 1 again. Because the full array is re-read for every one of the N·W cell placements, the test issues N·N·W reads. It can expose stuck-at cells, cells that cannot make one of the two transitions, and cells disturbed by writes to other cells.

The memory is driven through registered enable, write-enable, address and write-data pins and returns read data one cycle after the address. The controller flags the first mismatch it sees and records where it happened. It does not stop at that mismatch, so every run takes the same number of cycles whatever the memory contains. A one-cycle `done` pulse marks the end of the run. `fail` and the captured location stay valid until the next start or reset.

Top module: `galpat_bist`

## Requirements
- R1: A synchronous active-high reset returns the controller to idle from any state. In the cycle after reset, `busy`, `done`, `fail`, `mem_en` and `mem_we` are all 0.
- R2: The cycle after a start is accepted in idle, `busy` rises. The first N memory operations are then writes of all-zero data to addresses 0, 1, ..., N-1 in ascending order.
- R3: After the clearing writes, the k-th nonzero write (k = 0 .. N·W-1) goes to address k / W with data 1 << (k mod W). The lone 1 therefore walks from bit 0 to bit W-1 of a word before it moves to the next address. Every write carries at most one set bit.
- R4: Each placement write is followed by exactly N reads of addresses 0 .. N-1 in ascending order, then by an all-zero write to the placement address. A run therefore issues N·N·W reads and N + 2·N·W writes. `mem_en` is high only while `busy`.
- R5: Read data is taken one cycle after its address. It must equal the one-hot placement word at the placement address and zero at every other address. Any mismatch raises `fail`. `fail` stays high until reset or until a new start is accepted, and in the cycle after an accepted start `fail` is 0.
- R6: On the first mismatch of a run, the controller captures `fail_addr` (the read address), `fail_mask` (expected XOR read data) and `fail_bit` (index of the lowest set bit of `fail_mask`). Later mismatches leave these three outputs unchanged.
- R7: The run length is fixed. Count the cycle after the edge that accepts start as cycle 1. `done` is high for exactly one cycle, in cycle N + N·W·(N+2) + 3, whether or not a mismatch occurred. `busy` is low in that cycle.
- R8: A start request while `busy` is high is ignored. The run keeps its length, no extra `done` pulse appears, and `fail` is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a test run (accepted only while idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | At least one mismatch seen in this run |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_mask | output | DATA_W | Expected XOR read data at the first mismatch |
| fail_bit | output | BIT_W | Lowest failing bit index at the first mismatch |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after the address |

## Verification
From the ports, the hardest case to create is a mismatch that appears only after one particular cell has been set or cleared. A coupled victim, or a cell that cannot fall back to 0, reads correctly for many placements and breaks only at a single point deep inside the quadratic walk. The bench models the memory behaviourally, with stuck-at-0, stuck-at-1, rise-only (transition) and aggressor/victim coupling faults that can be placed at chosen cells. It predicts the exact placement at which each fault first shows. A run with two faults checks that only the earliest one is captured. A mid-run start and a mid-run reset cover the edge behaviour.

// File: rtl/galpat_pkg.sv
package galpat_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_SET,
    ST_SCAN,
    ST_RESTORE,
    ST_DRAIN
  } gp_state_e;

endpackage

// File: rtl/galpat_seq.sv
module galpat_seq
  import galpat_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              chk_vld,
  output logic [DATA_W-1:0] chk_exp
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_W - 1);

  gp_state_e         state;
  logic [ADDR_W-1:0] base_addr;
  logic [BIT_W-1:0]  base_bit;
  logic [ADDR_W-1:0] walk_addr;
  logic              drain_q;
  logic [DATA_W-1:0] base_word;

  logic              nxt_en, nxt_we, nxt_chk;
  logic [ADDR_W-1:0] nxt_addr;
  logic [DATA_W-1:0] nxt_wdata, nxt_exp;

  assign busy      = (state != ST_IDLE);
  assign base_word = DATA_W'(1) << base_bit;

  // Memory action chosen by the current state; registered onto the pins.
  always_comb begin
    nxt_en    = 1'b0;
    nxt_we    = 1'b0;
    nxt_chk   = 1'b0;
    nxt_addr  = '0;
    nxt_wdata = '0;
    nxt_exp   = '0;
    case (state)
      ST_CLEAR: begin
        nxt_en   = 1'b1;
        nxt_we   = 1'b1;
        nxt_addr = walk_addr;
      end
      ST_SET: begin
        nxt_en    = 1'b1;
        nxt_we    = 1'b1;
        nxt_addr  = base_addr;
        nxt_wdata = base_word;
      end
      ST_SCAN: begin
        nxt_en   = 1'b1;
        nxt_chk  = 1'b1;
        nxt_addr = walk_addr;
        nxt_exp  = (walk_addr == base_addr) ? base_word : '0;
      end
      ST_RESTORE: begin
        nxt_en   = 1'b1;
        nxt_we   = 1'b1;
        nxt_addr = base_addr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      chk_vld   <= 1'b0;
      chk_exp   <= '0;
    end else begin
      mem_en    <= nxt_en;
      mem_we    <= nxt_we;
      mem_addr  <= nxt_addr;
      mem_wdata <= nxt_wdata;
      chk_vld   <= nxt_chk;
      chk_exp   <= nxt_exp;
    end
  end

  // Phase sequencing and base-cell walk.
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      base_addr <= '0;
      base_bit  <= '0;
      walk_addr <= '0;
      drain_q   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_CLEAR;
            base_addr <= '0;
            base_bit  <= '0;
            walk_addr <= '0;
          end
        end
        ST_CLEAR: begin
          walk_addr <= walk_addr + 1'b1;
          if (walk_addr == LAST_ADDR) state <= ST_SET;
        end
        ST_SET: begin
          state <= ST_SCAN;
        end
        ST_SCAN: begin
          walk_addr <= walk_addr + 1'b1;
          if (walk_addr == LAST_ADDR) state <= ST_RESTORE;
        end
        ST_RESTORE: begin
          if (base_bit == LAST_BIT) begin
            base_bit <= '0;
            if (base_addr == LAST_ADDR) begin
              state   <= ST_DRAIN;
              drain_q <= 1'b0;
            end else begin
              base_addr <= base_addr + 1'b1;
              state     <= ST_SET;
            end
          end else begin
            base_bit <= base_bit + 1'b1;
            state    <= ST_SET;
          end
        end
        ST_DRAIN: begin
          drain_q <= 1'b1;
          if (drain_q) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_WDATA_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $onehot0(mem_wdata)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

endmodule

// File: rtl/galpat_cmp.sv
module galpat_cmp #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              chk_vld,
  input  logic [DATA_W-1:0] chk_exp,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_mask,
  output logic [BIT_W-1:0]  fail_bit
);

  logic              vld_d;
  logic [DATA_W-1:0] exp_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] diff;
  logic              mism;
  logic [BIT_W-1:0]  low_idx;

  // One stage delay lines the expectation up with the returned read data.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_d  <= 1'b0;
      exp_d  <= '0;
      addr_d <= '0;
    end else begin
      vld_d  <= chk_vld;
      exp_d  <= chk_exp;
      addr_d <= chk_addr;
    end
  end

  assign diff = exp_d ^ mem_rdata;
  assign mism = vld_d && (diff != '0);

  always_comb begin
    low_idx = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (diff[i]) low_idx = BIT_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_mask <= '0;
      fail_bit  <= '0;
    end else if (mism && !fail) begin
      fail      <= 1'b1;
      fail_addr <= addr_d;
      fail_mask <= diff;
      fail_bit  <= low_idx;
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail && !clr) |=> fail); // R5

  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (rst)
    (fail && !clr) |=> ($stable(fail_addr) && $stable(fail_mask) && $stable(fail_bit))); // R6

endmodule

// File: rtl/galpat_bist.sv
module galpat_bist #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_mask,
  output logic [BIT_W-1:0]  fail_bit,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic              chk_vld;
  logic [DATA_W-1:0] chk_exp;
  logic              run_clr;

  assign run_clr = start && !busy;

  galpat_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .chk_vld   (chk_vld),
    .chk_exp   (chk_exp)
  );

  galpat_cmp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BIT_W  (BIT_W)
  ) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .clr       (run_clr),
    .chk_vld   (chk_vld),
    .chk_exp   (chk_exp),
    .chk_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_mask (fail_mask),
    .fail_bit  (fail_bit)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy && !done && !fail && !mem_en && !mem_we)); // R1

  AST_EN_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> busy); // R4

endmodule

// File: tb/galpat_bist_bench.sv
module galpat_bist_bench;

  localparam int AW      = 4;
  localparam int DW      = 8;
  localparam int BW      = 3;
  localparam int DEPTH   = 1 << AW;
  localparam int CELLS   = DEPTH * DW;
  localparam int RUN_CYC = DEPTH + CELLS * (DEPTH + 2) + 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          busy, done, fail;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_mask;
  logic [BW-1:0] fail_bit;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  always #2 clk = ~clk;

  galpat_bist #(.ADDR_W(AW), .DATA_W(DW)) u_galpat_bist (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .fail(fail),
    .fail_addr(fail_addr), .fail_mask(fail_mask), .fail_bit(fail_bit),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // ---------------- behavioural memory with injectable faults ----------------
  logic [DW-1:0] mem [DEPTH];
  logic          wipe = 1'b0;
  logic          sa1a_en = 0, sa1b_en = 0, sa0_en = 0, tf_en = 0, cf_en = 0;
  int            sa1a_adr, sa1a_bit, sa1b_adr, sa1b_bit, sa0_adr, sa0_bit;
  int            tf_adr, tf_bit, cfa_adr, cfa_bit, cfv_adr, cfv_bit;

  function automatic logic [DW-1:0] read_word(input int a, input logic [DW-1:0] w);
    logic [DW-1:0] r;
    r = w;
    if (sa1a_en && a == sa1a_adr) r[sa1a_bit] = 1'b1;
    if (sa1b_en && a == sa1b_adr) r[sa1b_bit] = 1'b1;
    if (sa0_en  && a == sa0_adr)  r[sa0_bit]  = 1'b0;
    return r;
  endfunction

  always @(posedge clk) begin
    if (wipe) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (mem_en) begin
      mem_rdata <= read_word(int'(mem_addr), mem[mem_addr]);
      if (mem_we) begin
        logic [DW-1:0] nw;
        nw = mem_wdata;
        if (tf_en && int'(mem_addr) == tf_adr && mem[mem_addr][tf_bit]) nw[tf_bit] = 1'b1;
        mem[mem_addr] <= nw;
        if (cf_en && int'(mem_addr) == cfa_adr && mem_wdata[cfa_bit])
          mem[cfv_adr][cfv_bit] <= 1'b1;
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic efail;
    int   eaddr;
    int   emask;
    int   ebit;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor state
  logic armed = 1'b0;
  int   cnt, wr_cnt, rd_cnt, set_cnt, clr_err, set_err, rd_err, rst_err, last_set;

  always @(negedge clk) begin
    if (rst) begin
      armed = 1'b0;
    end else begin
      if (armed) begin
        cnt++;
        if (mem_en && mem_we) begin
          if (wr_cnt < DEPTH) begin
            if (int'(mem_addr) != wr_cnt || mem_wdata != '0) clr_err++;
          end else if (mem_wdata != '0) begin
            if (int'(mem_addr) != set_cnt / DW ||
                mem_wdata != (DW'(1) << (set_cnt % DW))) set_err++;
            last_set = int'(mem_addr);
            set_cnt++;
          end else begin
            if (int'(mem_addr) != last_set) rst_err++;
          end
          wr_cnt++;
        end else if (mem_en) begin
          if (int'(mem_addr) != rd_cnt % DEPTH) rd_err++;
          rd_cnt++;
        end
        if (done) begin
          armed = 1'b0;
          chk("R7", "run length", cnt, RUN_CYC);
          chk("R7", "busy at done", int'(busy), 0);
          chk("R2", "clear order errors", clr_err, 0);
          chk("R3", "placement order errors", set_err, 0);
          chk("R3", "placement count", set_cnt, CELLS);
          chk("R4", "read order errors", rd_err, 0);
          chk("R4", "restore address errors", rst_err, 0);
          chk("R4", "read count", rd_cnt, CELLS * DEPTH);
          chk("R4", "write count", wr_cnt, DEPTH + 2 * CELLS);
          if (exp_q.size() == 0) begin
            chk("R7", "unexpected done", 1, 0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk("R5", "fail", int'(fail), int'(e.efail));
            if (e.efail) begin
              chk("R6", "fail_addr", int'(fail_addr), e.eaddr);
              chk("R6", "fail_mask", int'(fail_mask), e.emask);
              chk("R6", "fail_bit",  int'(fail_bit),  e.ebit);
            end
          end
        end
      end else if (done) begin
        chk("R8", "done outside a run", 1, 0);
      end
      if (start && !busy) begin
        armed = 1'b1;
        cnt = 0; wr_cnt = 0; rd_cnt = 0; set_cnt = 0;
        clr_err = 0; set_err = 0; rd_err = 0; rst_err = 0; last_set = -1;
      end
    end
  end

  // ---------------- driver ----------------
  task automatic no_faults();
    sa1a_en = 0; sa1b_en = 0; sa0_en = 0; tf_en = 0; cf_en = 0;
  endtask

  task automatic wipe_mem();
    @(posedge clk); #1 wipe = 1'b1;
    @(posedge clk); #1 wipe = 1'b0;
  endtask

  task automatic launch();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk("R2", "busy after start", int'(busy), 1);
    chk("R5", "fail cleared by start", int'(fail), 0);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_case(input logic efail, input int ea, input int em, input int eb);
    exp_t e;
    e.efail = efail; e.eaddr = ea; e.emask = em; e.ebit = eb;
    wipe_mem();
    exp_q.push_back(e);
    launch();
    wait_done();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "fail after reset", int'(fail), 0);
    chk("R1", "mem_en after reset", int'(mem_en), 0);
    chk("R1", "done after reset", int'(done), 0);

    no_faults();
    run_case(1'b0, 0, 0, 0);                          // clean array

    no_faults(); sa1a_en = 1; sa1a_adr = 5; sa1a_bit = 3;
    run_case(1'b1, 5, 8'h08, 3);                      // stuck-at-1

    no_faults(); sa0_en = 1; sa0_adr = 9; sa0_bit = 6;
    run_case(1'b1, 9, 8'h40, 6);                      // stuck-at-0

    no_faults(); tf_en = 1; tf_adr = 2; tf_bit = 1;
    run_case(1'b1, 2, 8'h02, 1);                      // cannot fall to 0

    no_faults(); cf_en = 1; cfa_adr = 1; cfa_bit = 0; cfv_adr = 12; cfv_bit = 4;
    run_case(1'b1, 12, 8'h10, 4);                     // coupling

    no_faults();
    sa1a_en = 1; sa1a_adr = 5; sa1a_bit = 3;
    sa1b_en = 1; sa1b_adr = 3; sa1b_bit = 7;
    run_case(1'b1, 3, 8'h80, 7);                      // R6: earliest of two captured

    // R8: start pulses during a run are ignored
    begin
      exp_t e;
      no_faults(); sa1a_en = 1; sa1a_adr = 0; sa1a_bit = 2;
      e.efail = 1'b1; e.eaddr = 0; e.emask = 8'h04; e.ebit = 2;
      wipe_mem();
      exp_q.push_back(e);
      launch();
      repeat (300) @(negedge clk);
      chk("R8", "fail set before ignored start", int'(fail), 1);
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      @(negedge clk);
      chk("R8", "fail kept after ignored start", int'(fail), 1);
      chk("R8", "busy kept after ignored start", int'(busy), 1);
      wait_done();
      repeat (20) @(negedge clk);
      chk("R8", "no second run", int'(busy), 0);
    end

    // R1: reset in the middle of a failing run
    no_faults(); sa1a_en = 1; sa1a_adr = 0; sa1a_bit = 5;
    wipe_mem();
    launch();
    repeat (200) @(negedge clk);
    chk("R1", "fail before mid-run reset", int'(fail), 1);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy after mid-run reset", int'(busy), 0);
    chk("R1", "fail after mid-run reset", int'(fail), 0);
    chk("R1", "mem_we after mid-run reset", int'(mem_we), 0);

    no_faults();
    run_case(1'b0, 0, 0, 0);                          // recovery run

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule